// File: doc/BRIEF.md
# Shared-Path Zero Comparator

This block decides how a single 64-bit operand relates to zero, in one of three interpretations: two's-complement signed integer, unsigned integer, or IEEE double-precision floating point. It is used beside an integer and floating-point datapath so that branch and select logic can test an operand against zero without going through a full adder or a floating-point comparator.

All modes share one zero-detect structure. The operand is split into a top sign bit, an 11-bit upper field (the double exponent) and a 52-bit lower field (the double fraction). Each field gets its own all-zero test. The integer modes combine the two field tests with the sign bit. The floating-point mode adds a few terms: an all-ones test on the upper field for infinity and NaN, and a check on the fraction's top bit to tell signaling NaNs from quiet ones. These give exact IEEE results for negative zero, subnormals, infinities and NaNs.

A result is registered one clock after the input strobe. The flags hold their value until the next strobed operand arrives.

Top module: `zcmp_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied, and on the first clock after it is released with no strobe, every output is 0.
- R2: `res_valid` equals `op_valid` delayed by one clock. The flags are loaded only on a clock where `op_valid` is 1, and otherwise keep their last value.
- R3: Mode code 0 (signed integer): `res_lt` is operand bit 63. `res_eq` is 1 only when all 64 bits are 0. `res_gt` is 1 when bit 63 is 0 and the operand is non-zero. `res_unord` and `res_inv` are 0.
- R4: Mode code 1 (unsigned integer): `res_lt` is always 0. `res_eq` is 1 only for an all-zero operand. `res_gt` is 1 for any non-zero operand. `res_unord` and `res_inv` are 0.
- R5: Mode code 2 (double): both +0.0 (all bits 0) and -0.0 (only bit 63 set) give `res_eq`=1 and `res_lt`=`res_gt`=0.
- R6: Mode code 2: a subnormal (bits 62:52 all 0, bits 51:0 non-zero) is not equal to zero. It gives `res_lt` when bit 63 is 1 and `res_gt` when bit 63 is 0.
- R7: Mode code 2: a normal number, or an infinity (bits 62:52 all 1, bits 51:0 all 0), gives `res_lt` or `res_gt` from bit 63 alone.
- R8: Mode code 2: a NaN (bits 62:52 all 1, bits 51:0 non-zero) gives `res_unord`=1 and `res_eq`=`res_lt`=`res_gt`=0.
- R9: `res_inv` is 1 only for a signaling NaN in mode code 2, that is a NaN whose bit 51 is 0. A quiet NaN (bit 51 is 1) leaves it at 0.
- R10: Mode code 3 is reserved and produces the same flags as mode code 0.
- R11: For every valid result, exactly one of `res_eq`, `res_lt`, `res_gt` and `res_unord` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand strobe |
| op_mode | input | 2 | 0 signed, 1 unsigned, 2 double, 3 reserved (acts as signed) |
| op_data | input | 64 | Operand |
| res_valid | output | 1 | Result valid, one clock after the strobe |
| res_eq | output | 1 | Operand equals zero |
| res_lt | output | 1 | Operand below zero |
| res_gt | output | 1 | Operand above zero |
| res_unord | output | 1 | Operand is a NaN (double mode) |
| res_inv | output | 1 | Operand is a signaling NaN (double mode) |

## Verification
Directed operands cover the points where the three interpretations differ:
- Negative zero is equal in double mode but negative in signed mode and positive in unsigned mode.
- The smallest subnormals of both signs separate the fraction-only zero test from the full zero test.
- Infinities show that only the sign decides the result once NaNs are removed.
- Quiet and signaling NaNs split the unordered flag from the invalid flag.
- The all-ones pattern and the most negative integer separate the signed and unsigned readings of bit 63.

Random operands are then drawn with a bias toward the extreme exponent fields, so that zero, subnormal, infinity and NaN patterns occur often in every mode, including the reserved code. Strobe-free gaps check that the flags hold their last value.

// File: rtl/zcmp_pkg.sv
package zcmp_pkg;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned EXP_W  = 11;
    localparam int unsigned FRAC_W = DATA_W - 1 - EXP_W;

    typedef enum logic [1:0] {
        MODE_SINT = 2'd0,
        MODE_UINT = 2'd1,
        MODE_DBL  = 2'd2,
        MODE_RSVD = 2'd3
    } zmode_e;

    typedef struct packed {
        logic sign;
        logic upper_zero;
        logic upper_ones;
        logic lower_zero;
        logic lower_msb;
    } zfields_t;

    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
        logic unord;
        logic inv;
    } zflags_t;
endpackage

// File: rtl/zcmp_split.sv
module zcmp_split
    import zcmp_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned EW = EXP_W
) (
    input  logic [W-1:0] operand,
    output zfields_t     fields
);
    localparam int unsigned FW = W - 1 - EW;

    logic [EW-1:0] upper;
    logic [FW-1:0] lower;

    always_comb begin
        upper             = operand[W-2 -: EW];
        lower             = operand[FW-1:0];
        fields.sign       = operand[W-1];
        fields.upper_zero = ~|upper;
        fields.upper_ones = &upper;
        fields.lower_zero = ~|lower;
        fields.lower_msb  = lower[FW-1];
    end
endmodule

// File: rtl/zcmp_decide.sv
module zcmp_decide
    import zcmp_pkg::*;
(
    input  zfields_t fields,
    input  zmode_e   mode,
    output zflags_t  flags
);
    logic mag_zero;
    logic is_nan;

    always_comb begin
        mag_zero = fields.upper_zero & fields.lower_zero;
        is_nan   = fields.upper_ones & ~fields.lower_zero;
        flags    = '0;
        unique case (mode)
            MODE_UINT: begin
                flags.eq = mag_zero & ~fields.sign;
                flags.gt = ~(mag_zero & ~fields.sign);
            end
            MODE_DBL: begin
                flags.unord = is_nan;
                flags.inv   = is_nan & ~fields.lower_msb;
                flags.eq    = mag_zero;
                flags.lt    = ~is_nan & ~mag_zero & fields.sign;
                flags.gt    = ~is_nan & ~mag_zero & ~fields.sign;
            end
            MODE_SINT, MODE_RSVD: begin
                flags.eq = mag_zero & ~fields.sign;
                flags.lt = fields.sign;
                flags.gt = ~fields.sign & ~mag_zero;
            end
            default: flags = '0;
        endcase
    end
endmodule

// File: rtl/zcmp_unit.sv
module zcmp_unit
    import zcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_mode,
    input  logic [DATA_W-1:0] op_data,
    output logic              res_valid,
    output logic              res_eq,
    output logic              res_lt,
    output logic              res_gt,
    output logic              res_unord,
    output logic              res_inv
);
    zfields_t fields;
    zflags_t  next_flags;
    zflags_t  flags_q;
    logic     valid_q;

    zcmp_split #(.W(DATA_W), .EW(EXP_W)) u_split (
        .operand (op_data),
        .fields  (fields)
    );

    zcmp_decide u_decide (
        .fields (fields),
        .mode   (zmode_e'(op_mode)),
        .flags  (next_flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            flags_q <= '0;
        end else begin
            valid_q <= op_valid;
            if (op_valid) flags_q <= next_flags;
        end
    end

    always_comb begin
        res_valid = valid_q;
        res_eq    = flags_q.eq;
        res_lt    = flags_q.lt;
        res_gt    = flags_q.gt;
        res_unord = flags_q.unord;
        res_inv   = flags_q.inv;
    end
endmodule

// File: rtl/zcmp_unit_chk.sv
module zcmp_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [1:0]  op_mode,
    input logic [63:0] op_data,
    input logic        res_valid,
    input logic        res_eq,
    input logic        res_lt,
    input logic        res_gt,
    input logic        res_unord,
    input logic        res_inv
);
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (res_valid == $past(op_valid))); // R2

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_eq, res_lt, res_gt, res_unord}) == 1)); // R11

    AST_UINT_NEVER_LT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode == 2'd1) |=> !res_lt); // R4

    AST_NEG_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode == 2'd2 && op_data == 64'h8000_0000_0000_0000) |=> res_eq); // R5

    AST_UNORD_ONLY_DBL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode != 2'd2) |=> (!res_unord && !res_inv)); // R3

    AST_INV_NEEDS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        res_inv |-> res_unord); // R9

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !op_valid) |=> $stable({res_eq, res_lt, res_gt, res_unord, res_inv})); // R2
endmodule

bind zcmp_unit zcmp_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_mode   (op_mode),
    .op_data   (op_data),
    .res_valid (res_valid),
    .res_eq    (res_eq),
    .res_lt    (res_lt),
    .res_gt    (res_gt),
    .res_unord (res_unord),
    .res_inv   (res_inv)
);

// File: tb/zcmp_unit_tb.sv
module zcmp_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_mode = 2'd0;
    logic [63:0] op_data = '0;
    logic        res_valid, res_eq, res_lt, res_gt, res_unord, res_inv;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    logic [4:0]  last_exp = '0;

    always #4 clk = ~clk;

    zcmp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
        .op_data(op_data), .res_valid(res_valid), .res_eq(res_eq),
        .res_lt(res_lt), .res_gt(res_gt), .res_unord(res_unord), .res_inv(res_inv)
    );

    // expected flags {eq, lt, gt, unord, inv}
    function automatic logic [4:0] model(input logic [1:0] m, input logic [63:0] d);
        logic s, ez, eo, fz, nan;
        s  = d[63];
        ez = (d[62:52] == 11'h000);
        eo = (d[62:52] == 11'h7FF);
        fz = (d[51:0] == 52'd0);
        if (m == 2'd1) return {d == 64'd0, 1'b0, d != 64'd0, 2'b00};
        if (m == 2'd2) begin
            nan = eo & ~fz;
            if (nan) return {3'b000, 1'b1, ~d[51]};
            if (ez & fz) return 5'b10000;
            return {1'b0, s, ~s, 2'b00};
        end
        return {d == 64'd0, s, ~s & (d != 64'd0), 2'b00};
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got {v,eq,lt,gt,un,inv}=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {res_valid, res_eq, res_lt, res_gt, res_unord, res_inv};
    endfunction

    task automatic apply(input string req, input logic [1:0] m, input logic [63:0] d);
        @(negedge clk);
        op_valid = 1'b1; op_mode = m; op_data = d;
        @(negedge clk);
        op_valid = 1'b0;
        last_exp = model(m, d);
        check(req, outs(), {1'b1, last_exp});
    endtask

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        op_valid = 1'b1; op_mode = 2'd2; op_data = 64'h7FF0_0000_0000_0001;
        repeat (3) @(negedge clk);
        check("R1 in reset", outs(), 6'b0);
        op_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", outs(), 6'b0);

        apply("R3 zero", 2'd0, 64'd0);
        apply("R3 negative", 2'd0, 64'h8000_0000_0000_0000);
        apply("R3 positive", 2'd0, 64'd5);
        apply("R3 all ones", 2'd0, '1);
        apply("R4 all ones", 2'd1, '1);
        apply("R4 zero", 2'd1, 64'd0);
        apply("R4 -0 pattern", 2'd1, 64'h8000_0000_0000_0000);
        apply("R5 +0.0", 2'd2, 64'd0);
        apply("R5 -0.0", 2'd2, 64'h8000_0000_0000_0000);
        apply("R6 +subnormal", 2'd2, 64'd1);
        apply("R6 -subnormal", 2'd2, 64'h8000_0000_0000_0001);
        apply("R7 +inf", 2'd2, 64'h7FF0_0000_0000_0000);
        apply("R7 -inf", 2'd2, 64'hFFF0_0000_0000_0000);
        apply("R7 -1.0", 2'd2, 64'hBFF0_0000_0000_0000);
        apply("R8 qNaN", 2'd2, 64'h7FF8_0000_0000_0000);
        apply("R9 sNaN", 2'd2, 64'hFFF0_0000_0000_0001);
        apply("R10 reserved -0", 2'd3, 64'h8000_0000_0000_0000);
        apply("R10 reserved sNaN pattern", 2'd3, 64'h7FF0_0000_0000_0001);

        // R2: hold with no strobe, new operand ignored
        op_mode = 2'd1; op_data = 64'd0;
        @(negedge clk);
        check("R2 hold", outs(), {1'b0, last_exp});

        for (int i = 0; i < 2000; i++) begin
            logic [1:0]  m;
            logic [63:0] d;
            logic [2:0]  pick;
            m = 2'($urandom);
            d = {$urandom, $urandom};
            pick = 3'($urandom);
            if (pick == 3'd0) d[62:52] = 11'h000;
            if (pick == 3'd1) d[62:52] = 11'h7FF;
            if (pick == 3'd2) d[51:0]  = 52'd0;
            if (pick == 3'd3) d[62:0]  = 63'd0;
            apply("R11 random", m, d);
            if ($countones(outs() & 6'b011110) != 1) begin
                n_errors++;
                $display("FAIL R11: got %b expected exactly one of eq/lt/gt/unord", outs());
            end
            n_checks++;
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule